// File: doc/BRIEF.md
# Shared-Pool FIFO Partition Manager

This block owns one storage pool per direction (receive and transmit) and carves each pool into per-channel FIFO regions at run time. Software gives every channel a receive depth and a transmit depth. A depth of zero switches that channel's FIFO off. The new depths are staged first. They take effect when a global update pulse arrives while the direction is paused. The update lays the regions out one after another in channel order and empties every FIFO of that direction. After the update the direction stays paused until its pause request is released.

Each direction has one push stream and one pop stream, both valid/ready, with a channel select that travels alongside. A push fires on a cycle with `push_valid && push_ready`. `push_ready` depends only on the selected channel's state, and it is low when that channel is disabled, full or paused. A pop fires on a cycle with `pop_valid && pop_ready`. `pop_valid` and `pop_data` describe the head of the selected channel. `pop_valid` is low when that channel is empty or paused. A producer that sees `push_ready` low simply holds its word, and a stalled handshake never delays a pause.

A 16-bit global status word reports, per direction, the paused state, the all-empty state and whether the last update was rejected.

Top module: `pfm_top`

## Requirements
- R1: After reset the status word reads 0x0404 (both directions empty, none paused, no error), and no channel accepts a push because every depth is zero.
- R2: Writing a depth only stages it. The active layout changes only through an accepted update, and a channel whose active depth is zero never raises `push_ready`.
- R3: While a direction is paused, its `push_ready` and `pop_valid` stay low for every channel.
- R4: The paused flag of a direction rises on the clock after a cycle in which the pause request is high and no push or pop of that direction fires. It falls on the clock after a cycle in which the request is low.
- R5: The receive and transmit directions pause, update and transfer independently of each other.
- R6: An update taken while a direction is paused, with a total depth no larger than the pool, assigns region bases as the running sum of depths in channel order (channel 0 at base 0). It also clears every pointer and count of that direction, so the direction reads empty.
- R7: An update taken while a direction is paused, with a total depth larger than the pool, is rejected. The layout and the stored data stay as they were, and the error bit is set (bit 3 for receive, bit 11 for transmit). The next accepted update clears it. A total exactly equal to the pool is accepted.
- R8: An update that arrives while a direction is not paused has no effect on that direction: its layout, data and error bit are untouched.
- R9: Each channel returns its data in push order and holds exactly its active depth. `push_ready` drops once that many words are stored.
- R10: Status bit 1 means receive paused, bit 2 means all receive FIFOs empty, bit 9 means transmit paused, and bit 10 means all transmit FIFOs empty. When a direction reads all-empty, its `pop_valid` is low.
- R11: Regions of neighbouring channels do not overlap. Filling every enabled channel to its depth corrupts none of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Stage a depth for one channel |
| cfg_dir | input | 1 | Direction of staged depth (0 receive, 1 transmit) |
| cfg_ch | input | CHW | Channel of staged depth |
| cfg_size | input | SZW | Depth in words, 0 disables |
| update | input | 1 | Global commit pulse |
| rx_pause_req | input | 1 | Receive pause request (level) |
| tx_pause_req | input | 1 | Transmit pause request (level) |
| rx_push_valid | input | 1 | Receive push valid |
| rx_push_ch | input | CHW | Receive push channel |
| rx_push_data | input | DW | Receive push word |
| rx_push_ready | output | 1 | Receive push accepted |
| rx_pop_ch | input | CHW | Receive pop channel |
| rx_pop_ready | input | 1 | Receive pop taken |
| rx_pop_valid | output | 1 | Receive head word available |
| rx_pop_data | output | DW | Receive head word |
| tx_push_valid | input | 1 | Transmit push valid |
| tx_push_ch | input | CHW | Transmit push channel |
| tx_push_data | input | DW | Transmit push word |
| tx_push_ready | output | 1 | Transmit push accepted |
| tx_pop_ch | input | CHW | Transmit pop channel |
| tx_pop_ready | input | 1 | Transmit pop taken |
| tx_pop_valid | output | 1 | Transmit head word available |
| tx_pop_data | output | DW | Transmit head word |
| status | output | 16 | Global paused, empty and error flags |

## Verification
The hardest case to reach is a pause request that lands on the same cycle as a push that fires. The bench raises the request and a ready push together, and then checks that the paused flag is still low one clock later. It rises only after the push valid is withdrawn. A second difficult case is a rejected update while stored data is present. The bench loads a transmit channel, stages a layout larger than the pool, commits it under pause, and then unpauses and pops the old word to show that the layout survived. Region bases are never visible directly, so they are checked by filling neighbouring channels to depth and reading back every word.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  localparam int STAT_W      = 16;
  localparam int RX_PAUSED_B = 1;
  localparam int RX_EMPTY_B  = 2;
  localparam int RX_ERR_B    = 3;
  localparam int TX_PAUSED_B = 9;
  localparam int TX_EMPTY_B  = 10;
  localparam int TX_ERR_B    = 11;
  localparam int NDIR        = 2;
  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} pfm_dir_e;
endpackage

// File: rtl/pfm_alloc.sv
// Running-sum layout: base of channel i is the sum of depths of channels below i.
module pfm_alloc #(
  parameter int NCH = 4,
  parameter int SZW = 6,
  parameter int TW  = 9
) (
  input  logic [NCH-1:0][SZW-1:0] sizes,
  output logic [NCH-1:0][SZW-1:0] bases,
  output logic [TW-1:0]           total
);
  logic [NCH:0][TW-1:0] acc;
  assign acc[0] = '0;
  for (genvar i = 0; i < NCH; i++) begin : g_sum
    assign acc[i+1]  = acc[i] + TW'(sizes[i]);
    assign bases[i]  = acc[i][SZW-1:0];
  end
  assign total = acc[NCH];
endmodule

// File: rtl/pfm_dir.sv
// One direction: staged depths, active layout, pause handshake, pool storage.
module pfm_dir #(
  parameter int NCH  = 4,
  parameter int DW   = 8,
  parameter int POOL = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SZW = $clog2(POOL + 1),
  localparam int AW  = (POOL > 1) ? $clog2(POOL) : 1,
  localparam int TW  = SZW + CHW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [SZW-1:0] cfg_size,
  input  logic           update,
  input  logic           pause_req,
  input  logic           push_valid,
  input  logic [CHW-1:0] push_ch,
  input  logic [DW-1:0]  push_data,
  output logic           push_ready,
  input  logic [CHW-1:0] pop_ch,
  input  logic           pop_ready,
  output logic           pop_valid,
  output logic [DW-1:0]  pop_data,
  output logic           paused,
  output logic           empty,
  output logic           err
);
  logic [NCH-1:0][SZW-1:0] stage_q, size_q, base_q, wptr_q, rptr_q, cnt_q;
  logic [NCH-1:0][SZW-1:0] base_calc;
  logic [TW-1:0]           total;
  logic                    paused_q, err_q, over, commit, push_fire, pop_fire;
  logic [DW-1:0]           mem [POOL];

  pfm_alloc #(.NCH(NCH), .SZW(SZW), .TW(TW)) u_alloc (
    .sizes(stage_q), .bases(base_calc), .total(total)
  );

  function automatic logic [SZW-1:0] wrap_inc(input logic [SZW-1:0] p, input logic [SZW-1:0] lim);
    return (p + 1'b1 == lim) ? '0 : p + 1'b1;
  endfunction

  assign over       = total > TW'(POOL);
  assign commit     = update && paused_q && !over;
  assign push_ready = !paused_q && (size_q[push_ch] != '0) && (cnt_q[push_ch] != size_q[push_ch]);
  assign pop_valid  = !paused_q && (cnt_q[pop_ch] != '0);
  assign pop_data   = mem[AW'(base_q[pop_ch] + rptr_q[pop_ch])];
  assign push_fire  = push_valid && push_ready;
  assign pop_fire   = pop_valid && pop_ready;
  assign paused     = paused_q;
  assign empty      = (cnt_q == '0);
  assign err        = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else if (cfg_we) stage_q[cfg_ch] <= cfg_size;
  end

  always_ff @(posedge clk) begin
    if (push_fire) mem[AW'(base_q[push_ch] + wptr_q[push_ch])] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused_q <= 1'b0;
      err_q    <= 1'b0;
      size_q   <= '0;
      base_q   <= '0;
      wptr_q   <= '0;
      rptr_q   <= '0;
      cnt_q    <= '0;
    end else begin
      paused_q <= pause_req && (paused_q || !(push_fire || pop_fire));
      if (update && paused_q) err_q <= over;
      if (commit) begin
        size_q <= stage_q;
        base_q <= base_calc;
        wptr_q <= '0;
        rptr_q <= '0;
        cnt_q  <= '0;
      end else begin
        for (int i = 0; i < NCH; i++) begin
          if (push_fire && push_ch == CHW'(i)) wptr_q[i] <= wrap_inc(wptr_q[i], size_q[i]);
          if (pop_fire && pop_ch == CHW'(i))   rptr_q[i] <= wrap_inc(rptr_q[i], size_q[i]);
          if ((push_fire && push_ch == CHW'(i)) && !(pop_fire && pop_ch == CHW'(i)))
            cnt_q[i] <= cnt_q[i] + 1'b1;
          else if (!(push_fire && push_ch == CHW'(i)) && (pop_fire && pop_ch == CHW'(i)))
            cnt_q[i] <= cnt_q[i] - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pfm_top.sv
module pfm_top #(
  parameter int NCH  = 4,
  parameter int DW   = 8,
  parameter int POOL = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SZW = $clog2(POOL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic           cfg_dir,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [SZW-1:0] cfg_size,
  input  logic           update,
  input  logic           rx_pause_req,
  input  logic           tx_pause_req,
  input  logic           rx_push_valid,
  input  logic [CHW-1:0] rx_push_ch,
  input  logic [DW-1:0]  rx_push_data,
  output logic           rx_push_ready,
  input  logic [CHW-1:0] rx_pop_ch,
  input  logic           rx_pop_ready,
  output logic           rx_pop_valid,
  output logic [DW-1:0]  rx_pop_data,
  input  logic           tx_push_valid,
  input  logic [CHW-1:0] tx_push_ch,
  input  logic [DW-1:0]  tx_push_data,
  output logic           tx_push_ready,
  input  logic [CHW-1:0] tx_pop_ch,
  input  logic           tx_pop_ready,
  output logic           tx_pop_valid,
  output logic [DW-1:0]  tx_pop_data,
  output logic [15:0]    status
);
  import pfm_pkg::*;

  logic [NDIR-1:0]          pause_req, push_valid, push_ready, pop_ready, pop_valid;
  logic [NDIR-1:0]          paused, empty, err;
  logic [NDIR-1:0][CHW-1:0] push_ch, pop_ch;
  logic [NDIR-1:0][DW-1:0]  push_data, pop_data;

  assign pause_req  = {tx_pause_req, rx_pause_req};
  assign push_valid = {tx_push_valid, rx_push_valid};
  assign push_ch    = {tx_push_ch, rx_push_ch};
  assign push_data  = {tx_push_data, rx_push_data};
  assign pop_ch     = {tx_pop_ch, rx_pop_ch};
  assign pop_ready  = {tx_pop_ready, rx_pop_ready};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    pfm_dir #(.NCH(NCH), .DW(DW), .POOL(POOL)) u_dir (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we && (cfg_dir == 1'(d))), .cfg_ch(cfg_ch), .cfg_size(cfg_size),
      .update(update), .pause_req(pause_req[d]),
      .push_valid(push_valid[d]), .push_ch(push_ch[d]), .push_data(push_data[d]),
      .push_ready(push_ready[d]),
      .pop_ch(pop_ch[d]), .pop_ready(pop_ready[d]), .pop_valid(pop_valid[d]),
      .pop_data(pop_data[d]),
      .paused(paused[d]), .empty(empty[d]), .err(err[d])
    );
  end

  assign rx_push_ready = push_ready[DIR_RX];
  assign tx_push_ready = push_ready[DIR_TX];
  assign rx_pop_valid  = pop_valid[DIR_RX];
  assign tx_pop_valid  = pop_valid[DIR_TX];
  assign rx_pop_data   = pop_data[DIR_RX];
  assign tx_pop_data   = pop_data[DIR_TX];

  always_comb begin
    status              = '0;
    status[RX_PAUSED_B] = paused[DIR_RX];
    status[RX_EMPTY_B]  = empty[DIR_RX];
    status[RX_ERR_B]    = err[DIR_RX];
    status[TX_PAUSED_B] = paused[DIR_TX];
    status[TX_EMPTY_B]  = empty[DIR_TX];
    status[TX_ERR_B]    = err[DIR_TX];
  end
endmodule

// File: rtl/pfm_checker.sv
module pfm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        update,
  input logic        rx_pause_req,
  input logic        tx_pause_req,
  input logic        rx_push_valid,
  input logic        rx_push_ready,
  input logic        rx_pop_valid,
  input logic        rx_pop_ready,
  input logic        tx_push_valid,
  input logic        tx_push_ready,
  input logic        tx_pop_valid,
  input logic        tx_pop_ready,
  input logic [15:0] status
);
  assert_rx_paused_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> (!rx_push_ready && !rx_pop_valid));
  assert_tx_paused_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status[9] |-> (!tx_push_ready && !tx_pop_valid));
  assert_rx_pause_after_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> ($past(rx_pause_req) && !$past(rx_push_valid && rx_push_ready)
                          && !$past(rx_pop_valid && rx_pop_ready)));
  assert_tx_pause_after_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[9]) |-> ($past(tx_pause_req) && !$past(tx_push_valid && tx_push_ready)
                          && !$past(tx_pop_valid && tx_pop_ready)));
  assert_rx_unpause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_pause_req |=> !status[1]);
  assert_tx_unpause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_pause_req |=> !status[9]);
  assert_rx_err_on_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> $past(update));
  assert_tx_err_on_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[11]) |-> $past(update));
  assert_rx_empty_no_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> !rx_pop_valid);
  assert_tx_empty_no_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status[10] |-> !tx_pop_valid);
endmodule

bind pfm_top pfm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .update(update),
  .rx_pause_req(rx_pause_req), .tx_pause_req(tx_pause_req),
  .rx_push_valid(rx_push_valid), .rx_push_ready(rx_push_ready),
  .rx_pop_valid(rx_pop_valid), .rx_pop_ready(rx_pop_ready),
  .tx_push_valid(tx_push_valid), .tx_push_ready(tx_push_ready),
  .tx_pop_valid(tx_pop_valid), .tx_pop_ready(tx_pop_ready),
  .status(status)
);

// File: tb/pfm_top_test.sv
`timescale 1ns/1ps
module pfm_top_test;
  localparam int NCH = 4, DW = 8, POOL = 32;
  localparam int CHW = 2, SZW = 6;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_dir = 0, update = 0;
  logic [CHW-1:0] cfg_ch = '0;
  logic [SZW-1:0] cfg_size = '0;
  logic rx_pause_req = 0, tx_pause_req = 0;
  logic rx_push_valid = 0, tx_push_valid = 0, rx_pop_ready = 0, tx_pop_ready = 0;
  logic [CHW-1:0] rx_push_ch = '0, tx_push_ch = '0, rx_pop_ch = '0, tx_pop_ch = '0;
  logic [DW-1:0] rx_push_data = '0, tx_push_data = '0;
  logic rx_push_ready, tx_push_ready, rx_pop_valid, tx_pop_valid;
  logic [DW-1:0] rx_pop_data, tx_pop_data;
  logic [15:0] status;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pfm_top #(.NCH(NCH), .DW(DW), .POOL(POOL)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic stage(input bit d, input int ch, input int sz);
    cfg_we = 1; cfg_dir = d; cfg_ch = CHW'(ch); cfg_size = SZW'(sz);
    tick();
    cfg_we = 0;
  endtask

  task automatic commit();
    update = 1; tick(); update = 0;
  endtask

  task automatic set_pause(input bit d, input bit v);
    if (d) tx_pause_req = v; else rx_pause_req = v;
    tick();
  endtask

  task automatic push(input bit d, input int ch, input int data, input bit exp_rdy, input string req);
    if (d) begin tx_push_valid = 1; tx_push_ch = CHW'(ch); tx_push_data = DW'(data); end
    else   begin rx_push_valid = 1; rx_push_ch = CHW'(ch); rx_push_data = DW'(data); end
    #0.5;
    check(req, d ? tx_push_ready : rx_push_ready, exp_rdy);
    tick();
    rx_push_valid = 0; tx_push_valid = 0;
  endtask

  task automatic pop(input bit d, input int ch, input bit exp_vld, input int exp_data, input string req);
    if (d) begin tx_pop_ready = 1; tx_pop_ch = CHW'(ch); end
    else   begin rx_pop_ready = 1; rx_pop_ch = CHW'(ch); end
    #0.5;
    check(req, d ? tx_pop_valid : rx_pop_valid, exp_vld);
    if (exp_vld) check(req, d ? tx_pop_data : rx_pop_data, exp_data);
    tick();
    rx_pop_ready = 0; tx_pop_ready = 0;
  endtask

  task automatic t_reset();
    check("R1 status", status, 32'h0404);
    rx_push_valid = 1; tx_push_valid = 1; #0.5;
    check("R1 rx ready", rx_push_ready, 0);
    check("R1 tx ready", tx_push_ready, 0);
    rx_push_valid = 0; tx_push_valid = 0; #0.5;
  endtask

  task automatic t_layout();
    set_pause(0, 1);
    check("R4 rx paused", status[1], 1);
    stage(0, 0, 3); stage(0, 1, 5); stage(0, 2, 0); stage(0, 3, 2);
    commit();
    check("R6 no err", status[3], 0);
    set_pause(0, 0);
    check("R4 rx unpaused", status[1], 0);
    for (int i = 0; i < 3; i++) push(0, 0, 'hA0 + i, 1, "R9 fill ch0");
    push(0, 0, 'hAF, 0, "R9 ch0 full");
    for (int i = 0; i < 5; i++) push(0, 1, 'hB0 + i, 1, "R11 fill ch1");
    push(0, 1, 'hBF, 0, "R9 ch1 full");
    push(0, 2, 'hC0, 0, "R2 ch2 disabled");
    for (int i = 0; i < 2; i++) push(0, 3, 'hD0 + i, 1, "R11 fill ch3");
    check("R10 rx not empty", status[2], 0);
    for (int i = 0; i < 5; i++) pop(0, 1, 1, 'hB0 + i, "R11 ch1 data");
    for (int i = 0; i < 3; i++) pop(0, 0, 1, 'hA0 + i, "R9 ch0 order");
    for (int i = 0; i < 2; i++) pop(0, 3, 1, 'hD0 + i, "R11 ch3 data");
    pop(0, 0, 0, 0, "R9 ch0 drained");
    check("R10 rx empty", status[2], 1);
  endtask

  task automatic t_pause_waits();
    push(0, 0, 'h11, 1, "R9 preload");
    rx_pause_req = 1;
    rx_push_valid = 1; rx_push_ch = 0; rx_push_data = 'h12;
    #0.5;
    check("R4 push fires with request", rx_push_ready, 1);
    tick();
    rx_push_valid = 0;
    check("R4 pause held off by push", status[1], 0);
    tick();
    check("R4 pause after idle", status[1], 1);
    push(0, 1, 'h13, 0, "R3 push blocked");
    pop(0, 0, 0, 0, "R3 pop blocked");
    commit();
    check("R6 update empties rx", status[2], 1);
    set_pause(0, 0);
    pop(0, 0, 0, 0, "R6 data discarded");
  endtask

  task automatic t_independent();
    set_pause(0, 1);
    check("R5 tx not paused", status[9], 0);
    set_pause(1, 1);
    for (int c = 0; c < NCH; c++) stage(1, c, 4);
    commit();
    set_pause(1, 0);
    push(1, 3, 'h77, 1, "R5 tx accepts");
    push(0, 0, 'h66, 0, "R5 rx still blocked");
    pop(1, 3, 1, 'h77, "R5 tx data");
    push(1, 0, 'h50, 1, "R5 tx ch0");
    push(1, 0, 'h51, 1, "R5 tx ch0");
    check("R10 status bits", status, 32'h0006);
  endtask

  task automatic t_ignored();
    stage(1, 0, 1);
    commit();
    push(1, 0, 'h52, 1, "R8 old depth kept");
    push(1, 0, 'h53, 1, "R8 old depth kept");
    push(1, 0, 'h54, 0, "R2 staged not active");
    pop(1, 0, 1, 'h50, "R8 data intact");
    pop(1, 0, 1, 'h51, "R8 data intact");
  endtask

  task automatic t_overflow();
    stage(1, 0, 30);
    set_pause(1, 1);
    commit();
    check("R7 tx err set", status[11], 1);
    check("R7 tx data kept", status[10], 0);
    set_pause(1, 0);
    pop(1, 0, 1, 'h52, "R7 layout kept");
    set_pause(1, 1);
    stage(1, 0, 20);
    commit();
    check("R7 exact fit accepted", status[11], 0);
    check("R6 tx emptied", status[10], 1);
    set_pause(1, 0);
    for (int i = 0; i < 20; i++) push(1, 0, i, 1, "R9 fill 20");
    push(1, 0, 'hEE, 0, "R9 depth 20 full");
    for (int i = 0; i < 4; i++) push(1, 1, 'h90 + i, 1, "R11 ch1 after big ch0");
    pop(1, 0, 1, 0, "R11 ch0 head intact");
    pop(1, 1, 1, 'h90, "R11 ch1 head");
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    tick();
    t_layout();
    t_pause_waits();
    t_independent();
    t_ignored();
    t_overflow();
    summary();
  end
endmodule